// File: doc/BRIEF.md
# Indexed Clock-Synthesizer Parameter Bank

This block is a small register bank inside a video DAC's byte-wide indexed register space. It stores the programming parameters for three clock synthesizers: pixel, memory and loop. One selector byte holds a 2-bit slot field for each synthesizer. Each synthesizer has its own data index, and the slot field chosen by the selector byte decides whether that index reaches the N, M or P parameter or the status slot.

Reads are combinational from the index and the current state. On the way out, each slot's value is shaped into a fixed bit signature, so that driver software probing the DAC finds the patterns it expects. The status slot always reports a locked synthesizer. Writes take effect on the rising clock edge while the write strobe is high. The asynchronous active-low reset is released synchronously, two clock edges after `rst_n` rises.

Top module: `pll_param_bank`

## Requirements
- R1: After reset the selector byte reads 0x00 and every stored parameter byte is 0x00, so an N slot first reads 0xC0.
- R2: Index 0x2C is the selector byte. It stores all 8 bits written to it and reads them back unchanged.
- R3: Index 0x2D reaches the pixel synthesizer through selector bits 1:0, index 0x2E reaches the memory synthesizer through bits 3:2, and index 0x2F reaches the loop synthesizer through bits 5:4. A write through one index leaves the other synthesizers' bytes unchanged.
- R4: Slot code 0 is N. Writes to N store the full byte, and a read returns the stored byte with bits 7 and 6 set.
- R5: Slot code 1 is M. Writes to M store the full byte, and a read returns the stored byte with bits 7 and 6 cleared.
- R6: Slot code 2 is P. Writes store the full byte. A read of the pixel P slot returns the stored byte OR 0x70.
- R7: A read of the memory P slot returns (stored AND 0x83) OR 0x30.
- R8: A read of the loop P slot returns (stored AND 0x8B) OR 0x70.
- R9: Slot code 3 is status. It always reads 0x40 (locked), and writes to it change no stored byte.
- R10: With the read strobe high, any index other than 0x2C to 0x2F reads 0x00. Writes to such an index change no state.
- R11: While the read strobe is low, the read data is 0x00.
- R12: A write lands on the rising clock edge. A read of the same index in the same cycle returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_idx | input | 8 | Register index |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_re | input | 1 | Read strobe |
| reg_rdata | output | 8 | Combinational read data |

## Verification
A write and a read can fall in the same cycle. This happens when the write strobe and the read strobe are both raised on one data index. The bench drives both strobes together on a pixel N slot that already holds a known byte. It samples the read data before the clock edge and expects the old value with its signature applied. After the edge it reads again and expects the newly written value with the same signature. The signature rules are also judged on every slot of every synthesizer with several data patterns, so that a forced bit and a preserved bit can be told apart.

// File: rtl/pll_bank_pkg.sv
package pll_bank_pkg;
  localparam int BYTE_W       = 8;
  localparam int NUM_SYN      = 3;
  localparam int SLOT_W       = 2;
  localparam int STORED_SLOTS = 3;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [SLOT_W-1:0] {
    SLOT_N    = 2'd0,
    SLOT_M    = 2'd1,
    SLOT_P    = 2'd2,
    SLOT_STAT = 2'd3
  } slot_e;

  typedef logic [STORED_SLOTS-1:0][BYTE_W-1:0] slot_bank_t;

  localparam byte_t STAT_LOCKED = 8'h40;
  localparam byte_t N_FORCE_SET = 8'hC0;
  localparam byte_t M_KEEP_MASK = 8'h3F;
endpackage

// File: rtl/pll_rst_sync.sv
module pll_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/pll_sel_reg.sv
module pll_sel_reg
  import pll_bank_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  byte_t wdata,
  output byte_t sel_q
);
  byte_t sel_d;
  logic  sel_en;

  always_comb begin
    sel_en = wr_en;
    sel_d  = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (sel_en) begin
      sel_q <= sel_d;
    end
  end
endmodule

// File: rtl/pll_syn_slots.sv
module pll_syn_slots
  import pll_bank_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  slot_e      slot,
  input  byte_t      wdata,
  output slot_bank_t bank_q
);
  slot_bank_t bank_d;
  logic       bank_en;

  always_comb begin
    bank_en = wr_en && (slot != SLOT_STAT);
    bank_d  = bank_q;
    for (int s = 0; s < STORED_SLOTS; s++) begin
      if (slot == slot_e'(s)) begin
        bank_d[s] = wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
    end else if (bank_en) begin
      bank_q <= bank_d;
    end
  end
endmodule

// File: rtl/pll_sig_fmt.sv
module pll_sig_fmt
  import pll_bank_pkg::*;
#(
  parameter int SYN_ID = 0
) (
  input  slot_e      slot,
  input  slot_bank_t bank,
  output byte_t      rdata
);
  localparam byte_t P_KEEP = (SYN_ID == 0) ? 8'hFF :
                             (SYN_ID == 1) ? 8'h83 : 8'h8B;
  localparam byte_t P_SET  = (SYN_ID == 1) ? 8'h30 : 8'h70;

  byte_t raw;

  always_comb begin
    raw = '0;
    for (int s = 0; s < STORED_SLOTS; s++) begin
      if (slot == slot_e'(s)) begin
        raw = bank[s];
      end
    end
  end

  always_comb begin
    unique case (slot)
      SLOT_N:    rdata = raw | N_FORCE_SET;
      SLOT_M:    rdata = raw & M_KEEP_MASK;
      SLOT_P:    rdata = (raw & P_KEEP) | P_SET;
      default:   rdata = STAT_LOCKED;
    endcase
  end
endmodule

// File: rtl/pll_param_bank.sv
module pll_param_bank
  import pll_bank_pkg::*;
#(
  parameter int              IDX_W   = 8,
  parameter logic [IDX_W-1:0] SEL_IDX = 8'h2C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [BYTE_W-1:0] reg_wdata,
  input  logic              reg_we,
  input  logic              reg_re,
  output logic [BYTE_W-1:0] reg_rdata
);
  logic               rst_sync_n;
  logic               sel_hit;
  logic [NUM_SYN-1:0] port_hit;
  byte_t              sel_q;
  slot_e              slot_w   [NUM_SYN];
  slot_bank_t         bank_w   [NUM_SYN];
  byte_t              port_rd  [NUM_SYN];
  byte_t              rdata_d;

  pll_rst_sync u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  assign sel_hit = (reg_idx == SEL_IDX);

  pll_sel_reg u_sel_reg (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .wr_en (reg_we && sel_hit),
    .wdata (reg_wdata),
    .sel_q (sel_q)
  );

  for (genvar k = 0; k < NUM_SYN; k++) begin : g_syn
    assign port_hit[k] = (reg_idx == SEL_IDX + IDX_W'(k + 1));
    assign slot_w[k]   = slot_e'(sel_q[SLOT_W*k +: SLOT_W]);

    pll_syn_slots u_slots (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .wr_en  (reg_we && port_hit[k]),
      .slot   (slot_w[k]),
      .wdata  (reg_wdata),
      .bank_q (bank_w[k])
    );

    pll_sig_fmt #(.SYN_ID(k)) u_fmt (
      .slot  (slot_w[k]),
      .bank  (bank_w[k]),
      .rdata (port_rd[k])
    );
  end

  always_comb begin
    rdata_d = '0;
    if (reg_re) begin
      if (sel_hit) begin
        rdata_d = sel_q;
      end
      for (int k = 0; k < NUM_SYN; k++) begin
        if (port_hit[k]) begin
          rdata_d = port_rd[k];
        end
      end
    end
  end

  assign reg_rdata = rdata_d;
endmodule

// File: rtl/pll_param_bank_chk.sv
module pll_param_bank_chk
  import pll_bank_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  reg_idx,
  input logic [7:0]  reg_wdata,
  input logic        reg_we,
  input logic        reg_re,
  input logic [7:0]  reg_rdata,
  input logic [7:0]  sel_q
);
  logic       is_port;
  logic [1:0] fld;

  always_comb begin
    is_port = 1'b1;
    fld     = 2'd0;
    case (reg_idx)
      8'h2D:   fld = sel_q[1:0];
      8'h2E:   fld = sel_q[3:2];
      8'h2F:   fld = sel_q[5:4];
      default: is_port = 1'b0;
    endcase
  end

  AST_SEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_idx == 8'h2C) |=> (sel_q == $past(reg_wdata))); // R2
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_idx == 8'h2C) |=> $stable(sel_q)); // R10
  AST_N_SIGNATURE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_re && is_port && fld == 2'd0) |-> (reg_rdata[7:6] == 2'b11)); // R4
  AST_M_SIGNATURE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_re && is_port && fld == 2'd1) |-> (reg_rdata[7:6] == 2'b00)); // R5
  AST_STATUS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_re && is_port && fld == 2'd3) |-> (reg_rdata == 8'h40)); // R9
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_re |-> (reg_rdata == 8'h00)); // R11
  AST_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_re && !is_port && reg_idx != 8'h2C) |-> (reg_rdata == 8'h00)); // R10
endmodule

bind pll_param_bank pll_param_bank_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .reg_idx   (reg_idx),
  .reg_wdata (reg_wdata),
  .reg_we    (reg_we),
  .reg_re    (reg_re),
  .reg_rdata (reg_rdata),
  .sel_q     (sel_q)
);

// File: tb/test_pll_param_bank.sv
`timescale 1ns/1ps
module test_pll_param_bank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] reg_idx = '0;
  logic [7:0] reg_wdata = '0;
  logic       reg_we = 1'b0;
  logic       reg_re = 1'b0;
  logic [7:0] reg_rdata;

  int n_chk  = 0;
  int n_fail = 0;
  logic [7:0] m_sel = '0;
  logic [7:0] m_par [3][3];

  always #5 clk = ~clk;

  pll_param_bank i_pll_param_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_idx   (reg_idx),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we),
    .reg_re    (reg_re),
    .reg_rdata (reg_rdata)
  );

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] expect_rd(int p, int s);
    logic [7:0] v;
    if (s == 3) return 8'h40;
    v = m_par[p][s];
    if (s == 0) return v | 8'hC0;
    if (s == 1) return v & 8'h3F;
    if (p == 0) return v | 8'h70;
    if (p == 1) return (v & 8'h83) | 8'h30;
    return (v & 8'h8B) | 8'h70;
  endfunction

  task automatic wr(logic [7:0] idx, logic [7:0] d);
    int p;
    @(negedge clk);
    reg_idx = idx; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk); #1;
    reg_we = 1'b0;
    if (idx == 8'h2C) m_sel = d;
    else if (idx >= 8'h2D && idx <= 8'h2F) begin
      p = int'(idx - 8'h2D);
      if (int'((m_sel >> (2*p)) & 8'h3) != 3) m_par[p][int'((m_sel >> (2*p)) & 8'h3)] = d;
    end
  endtask

  task automatic rd(logic [7:0] idx, output logic [7:0] got);
    @(negedge clk);
    reg_idx = idx; reg_re = 1'b1;
    #1 got = reg_rdata;
    reg_re = 1'b0;
  endtask

  task automatic point(int p, int s);
    wr(8'h2C, (m_sel & ~(8'h3 << (2*p))) | 8'((s & 3) << (2*p)));
  endtask

  task automatic t_reset;
    logic [7:0] g;
    rd(8'h2C, g); check("R1 selector", g, 8'h00);
    for (int p = 0; p < 3; p++) begin
      rd(8'h2D + 8'(p), g); check("R1 N slot", g, 8'hC0);
    end
  endtask

  task automatic t_selector;
    logic [7:0] g;
    wr(8'h2C, 8'hA7); rd(8'h2C, g); check("R2 readback A7", g, 8'hA7);
    wr(8'h2C, 8'h00); rd(8'h2C, g); check("R2 readback 00", g, 8'h00);
  endtask

  task automatic t_signatures;
    logic [7:0] g;
    logic [7:0] pats [4] = '{8'h00, 8'hFF, 8'hA5, 8'h5A};
    for (int p = 0; p < 3; p++)
      for (int s = 0; s < 3; s++)
        for (int i = 0; i < 4; i++) begin
          point(p, s);
          wr(8'h2D + 8'(p), pats[i]);
          rd(8'h2D + 8'(p), g);
          case (s)
            0: check("R4 N signature", g, expect_rd(p, s));
            1: check("R5 M signature", g, expect_rd(p, s));
            default: check(p == 0 ? "R6 pixel P" : p == 1 ? "R7 memory P" : "R8 loop P",
                           g, expect_rd(p, s));
          endcase
        end
  endtask

  task automatic t_isolation;
    logic [7:0] g;
    logic [7:0] vals [3] = '{8'h12, 8'h34, 8'h05};
    wr(8'h2C, 8'h00);
    for (int p = 0; p < 3; p++) wr(8'h2D + 8'(p), vals[p]);
    for (int p = 0; p < 3; p++) begin
      rd(8'h2D + 8'(p), g); check("R3 per-port N", g, expect_rd(p, 0));
    end
  endtask

  task automatic t_status;
    logic [7:0] g;
    for (int p = 0; p < 3; p++) begin
      point(p, 3);
      wr(8'h2D + 8'(p), 8'h99);
      rd(8'h2D + 8'(p), g); check("R9 status locked", g, 8'h40);
    end
    for (int p = 0; p < 3; p++)
      for (int s = 0; s < 3; s++) begin
        point(p, s);
        rd(8'h2D + 8'(p), g); check("R9 status write ignored", g, expect_rd(p, s));
      end
  endtask

  task automatic t_out_of_range;
    logic [7:0] g;
    wr(8'h2C, 8'h24);
    wr(8'h2B, 8'hFF); wr(8'h30, 8'hFF); wr(8'h00, 8'hFF);
    rd(8'h2C, g); check("R10 selector untouched", g, 8'h24);
    for (int p = 0; p < 3; p++) begin
      rd(8'h2D + 8'(p), g); check("R10 slots untouched", g, expect_rd(p, int'((m_sel >> (2*p)) & 8'h3)));
    end
    rd(8'h2B, g); check("R10 read 2B", g, 8'h00);
    rd(8'h30, g); check("R10 read 30", g, 8'h00);
  endtask

  task automatic t_idle;
    @(negedge clk);
    reg_idx = 8'h2C; reg_re = 1'b0;
    #1 check("R11 strobe low sel", reg_rdata, 8'h00);
    reg_idx = 8'h2D;
    #1 check("R11 strobe low port", reg_rdata, 8'h00);
  endtask

  task automatic t_same_cycle;
    logic [7:0] g;
    point(0, 0);
    wr(8'h2D, 8'h11);
    @(negedge clk);
    reg_idx = 8'h2D; reg_wdata = 8'h22; reg_we = 1'b1; reg_re = 1'b1;
    #1 check("R12 pre-edge old value", reg_rdata, 8'hD1);
    @(posedge clk); #1;
    reg_we = 1'b0; reg_re = 1'b0;
    m_par[0][0] = 8'h22;
    rd(8'h2D, g); check("R12 post-edge new value", g, 8'hE2);
  endtask

  initial begin
    for (int p = 0; p < 3; p++)
      for (int s = 0; s < 3; s++) m_par[p][s] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_selector();
    t_signatures();
    t_isolation();
    t_status();
    t_out_of_range();
    t_idle();
    t_same_cycle();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule